// File: doc/BRIEF.md
# ADC Ramp Test-Pattern Checker

This block watches the paired I/Q sample stream of a converter that has been put into its ramp test mode. It tells whether the capture path delivers every sample intact. Each lane is checked on its own. A lane waits until it sees a sample of value zero, then locks. From then on it expects each valid sample to be one greater than the last, wrapping at 14 bits. Any sample that differs sets a sticky error flag for that lane.

A calibration routine typically sweeps a capture delay and pulses the enable low and then high at each setting. It lets the stream run and then reads the four status flags to judge whether that setting gives clean data. The I lane reaches the block with its data bits inverted, and the checker undoes this before comparing.

Top module: `ramp_pattern_checker`

## Requirements
- R1: While `rst` is high, all four status outputs are 0 after the next rising clock edge, whatever the other inputs are.
- R2: The I value is the bitwise inverse of `smp_word[31:18]` and the Q value is `smp_word[15:2]`. Bits 17:16 and 1:0 have no effect on any output.
- R3: An enabled lane that is not locked stays unlocked while every valid sample it receives is nonzero.
- R4: A lane's locked flag rises at the clock edge at which the lane takes a valid sample of value zero.
- R5: After locking on zero, a lane expects the values 1, 2, 3 and so on, one step for each valid sample. Samples that match these values leave the error flag at 0.
- R6: The expected value wraps from 0x3FFF to 0x0000 without raising an error.
- R7: A valid sample that differs from the expected value on a locked lane sets that lane's error flag at that edge. The other lane's flags are unaffected.
- R8: While enable stays high, a set error flag and a set locked flag stay set, even after later samples match.
- R9: A cycle with `smp_vld` low changes no status flag and does not advance the expected value.
- R10: From the first clock edge at which `chk_en` is sampled low, all four outputs are 0.
- R11: When enable returns high after being low, both lanes start again unlocked and need a fresh zero sample to lock.
- R12: A lane that is not locked never sets its error flag, whatever data it receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_en | input | 1 | Check enable; low clears and holds both lanes idle |
| smp_vld | input | 1 | Sample word is valid this cycle |
| smp_word | input | 32 | I lane in the upper half (inverted), Q lane in the lower half, each left-justified |
| i_locked | output | 1 | I lane has locked onto the ramp |
| i_err | output | 1 | I lane has seen a mismatch since locking |
| q_locked | output | 1 | Q lane has locked onto the ramp |
| q_err | output | 1 | Q lane has seen a mismatch since locking |

## Verification
Suppose a lane's expected counter slips or fails to advance, or advances on an invalid cycle. On an otherwise clean ramp, that lane's error flag rises at the very next valid sample, one edge later. A wrong decode of the field or of the inversion shows in a similar way. Such a fault either locks the wrong lane on a raw zero word or flags errors on a ramp that is correct. A lost lock or error state shows as a flag that falls while enable is held high. A lane whose fault spills into its neighbour shows as an error on the lane that received clean data.

// File: rtl/rampchk_pkg.sv
package rampchk_pkg;

    localparam int LANE_W    = 16;
    localparam int DATA_W    = 14;
    localparam int PAD_W     = LANE_W - DATA_W;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    // lane index 0 is Q (low half), lane index 1 is I (high half)
    localparam int LANE_Q = 0;
    localparam int LANE_I = 1;

    typedef logic [DATA_W-1:0] ramp_val_t;

    typedef struct packed {
        logic      vld;
        ramp_val_t val;
    } lane_smp_t;

    typedef struct packed {
        logic locked;
        logic err;
    } lane_stat_t;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } lane_state_e;

    function automatic ramp_val_t ramp_next(input ramp_val_t v);
        return v + ramp_val_t'(1);
    endfunction

    function automatic ramp_val_t lane_field(input logic [LANE_W-1:0] half, input logic inv);
        ramp_val_t raw;
        raw = half[LANE_W-1 -: DATA_W];
        return inv ? ~raw : raw;
    endfunction

endpackage

// File: rtl/rampchk_unpack.sv
module rampchk_unpack
    import rampchk_pkg::*;
(
    input  logic [WORD_W-1:0]              word_i,
    input  logic                           vld_i,
    output lane_smp_t [NUM_LANES-1:0]      lanes_o
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam logic INV = (g == LANE_I);
        logic [LANE_W-1:0] half;
        assign half            = word_i[g*LANE_W +: LANE_W];
        assign lanes_o[g].vld  = vld_i;
        assign lanes_o[g].val  = lane_field(half, INV);
    end

endmodule

// File: rtl/rampchk_lane.sv
module rampchk_lane
    import rampchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  lane_smp_t  smp_i,
    output lane_stat_t stat_o
);

    lane_state_e state_q;
    ramp_val_t   expect_q;
    logic        err_q;
    logic        is_zero;
    logic        mismatch;

    assign is_zero  = (smp_i.val == '0);
    assign mismatch = (smp_i.val != expect_q);

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q  <= ST_HUNT;
            expect_q <= '0;
            err_q    <= 1'b0;
        end else if (smp_i.vld) begin
            case (state_q)
                ST_HUNT: begin
                    if (is_zero) begin
                        state_q  <= ST_TRACK;
                        expect_q <= ramp_next('0);
                    end
                end
                ST_TRACK: begin
                    if (mismatch) begin
                        err_q <= 1'b1;
                    end
                    expect_q <= ramp_next(expect_q);
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    assign stat_o.locked = (state_q == ST_TRACK);
    assign stat_o.err    = err_q;

    AST_ERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        stat_o.err |-> stat_o.locked); // R12

    AST_NO_LOCK_ON_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (!stat_o.locked && en_i && smp_i.vld && !is_zero) |=> !stat_o.locked); // R3

    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (stat_o.err && en_i) |=> stat_o.err); // R8

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!stat_o.locked && !stat_o.err)); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en_i && !smp_i.vld) |=> ($stable(stat_o.locked) && $stable(stat_o.err))); // R9

endmodule

// File: rtl/ramp_pattern_checker.sv
module ramp_pattern_checker
    import rampchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chk_en,
    input  logic              smp_vld,
    input  logic [WORD_W-1:0] smp_word,
    output logic              i_locked,
    output logic              i_err,
    output logic              q_locked,
    output logic              q_err
);

    lane_smp_t  [NUM_LANES-1:0] lanes;
    lane_stat_t [NUM_LANES-1:0] stats;

    rampchk_unpack u_unpack (
        .word_i  (smp_word),
        .vld_i   (smp_vld),
        .lanes_o (lanes)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
        rampchk_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .en_i   (chk_en),
            .smp_i  (lanes[g]),
            .stat_o (stats[g])
        );
    end

    assign i_locked = stats[LANE_I].locked;
    assign i_err    = stats[LANE_I].err;
    assign q_locked = stats[LANE_Q].locked;
    assign q_err    = stats[LANE_Q].err;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!i_locked && !i_err && !q_locked && !q_err)); // R1

endmodule

// File: tb/ramp_pattern_checker_test.sv
module ramp_pattern_checker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_en = 1'b0;
    logic        smp_vld = 1'b0;
    logic [31:0] smp_word = '0;
    logic        i_locked, i_err, q_locked, q_err;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ramp_pattern_checker uut (
        .clk      (clk),
        .rst      (rst),
        .chk_en   (chk_en),
        .smp_vld  (smp_vld),
        .smp_word (smp_word),
        .i_locked (i_locked),
        .i_err    (i_err),
        .q_locked (q_locked),
        .q_err    (q_err)
    );

    typedef struct {
        string      tag;
        logic [3:0] flags; // {i_locked, i_err, q_locked, q_err}
    } exp_item_t;

    exp_item_t sb_q[$];

    // bench model: index 0 = Q, 1 = I
    logic        m_lk [2];
    logic        m_er [2];
    logic [13:0] m_ex [2];

    function automatic logic [31:0] mk(input logic [13:0] iv, input logic [13:0] qv,
                                       input logic [3:0] pad);
        return {~iv, pad[3:2], qv, pad[1:0]};
    endfunction

    task automatic model_step(input logic en, input logic vld, input logic [31:0] w);
        logic [13:0] v [2];
        v[1] = ~w[31:18];
        v[0] = w[15:2];
        for (int l = 0; l < 2; l++) begin
            if (!en) begin
                m_lk[l] = 1'b0; m_er[l] = 1'b0; m_ex[l] = '0;
            end else if (vld) begin
                if (!m_lk[l]) begin
                    if (v[l] == 14'd0) begin
                        m_lk[l] = 1'b1; m_ex[l] = 14'd1;
                    end
                end else begin
                    if (v[l] != m_ex[l]) m_er[l] = 1'b1;
                    m_ex[l] = m_ex[l] + 14'd1;
                end
            end
        end
    endtask

    task automatic drive(input logic en, input logic vld, input logic [31:0] w, input string tag);
        exp_item_t it;
        @(negedge clk);
        chk_en   = en;
        smp_vld  = vld;
        smp_word = w;
        model_step(en, vld, w);
        it.tag   = tag;
        it.flags = {m_lk[1], m_er[1], m_lk[0], m_er[0]};
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        exp_item_t it;
        logic [3:0] act;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it  = sb_q.pop_front();
                act = {i_locked, i_err, q_locked, q_err};
                checks++;
                if (act !== it.flags) begin
                    failures++;
                    $display("FAIL %s: flags actual=%b expected=%b", it.tag, act, it.flags);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        for (int l = 0; l < 2; l++) begin
            m_lk[l] = 1'b0; m_er[l] = 1'b0; m_ex[l] = '0;
        end
        // R1: reset dominates enabled zero samples
        chk_en = 1'b1; smp_vld = 1'b1; smp_word = mk(14'd0, 14'd0, 4'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({i_locked, i_err, q_locked, q_err} !== 4'b0000) begin
            failures++;
            $display("FAIL R1: flags actual=%b expected=0000", {i_locked, i_err, q_locked, q_err});
        end
        rst = 1'b0; chk_en = 1'b0;

        // R10: disabled, zero samples do not lock
        for (int k = 0; k < 3; k++) drive(1'b0, 1'b1, mk(14'd0, 14'd0, 4'd0), "R10 disabled idle");

        // R3 / R12: nonzero and erratic samples while unlocked
        for (int k = 0; k < 6; k++)
            drive(1'b1, 1'b1, mk(14'(5 + k * 7), 14'(9 + k * 3), 4'(k)), "R3 R12 unlocked nonzero");

        // R2: raw all-zero word is Q = 0 but I = 0x3FFF, so only Q locks
        drive(1'b1, 1'b1, 32'h0000_0000, "R2 I inversion, Q locks");
        // R4: I now gets zero (Q continues at 1)
        drive(1'b1, 1'b1, mk(14'd0, 14'd1, 4'hF), "R4 I locks on zero");

        // R5 / R2: clean ramp with pad bits varying
        for (int k = 1; k < 40; k++)
            drive(1'b1, 1'b1, mk(14'(k), 14'(k + 1), 4'(k)), "R5 R2 clean ramp");

        // R9: invalid cycles carrying garbage
        for (int k = 0; k < 4; k++)
            drive(1'b1, 1'b0, 32'hDEAD_BEEF ^ 32'(k), "R9 invalid ignored");
        drive(1'b1, 1'b1, mk(14'd40, 14'd41, 4'd0), "R9 ramp resumes");

        // R11: restart, then full sweep through the wrap (R6)
        drive(1'b0, 1'b1, mk(14'd0, 14'd0, 4'd0), "R10 enable low clears");
        drive(1'b1, 1'b1, mk(14'd77, 14'd0, 4'd0), "R11 restart needs zero");
        drive(1'b1, 1'b1, mk(14'd0, 14'd1, 4'd0), "R11 relock");
        for (int k = 1; k < 16400; k++)
            drive(1'b1, 1'b1, mk(14'(k), 14'(k + 1), 4'(k)), "R6 wrap sweep");

        // R7: corrupt Q only
        drive(1'b1, 1'b1, mk(14'(16400), 14'h1234, 4'd0), "R7 Q mismatch");
        // R8: later clean samples keep error sticky
        for (int k = 16401; k < 16410; k++)
            drive(1'b1, 1'b1, mk(14'(k), 14'(k + 1), 4'd0), "R8 sticky error");
        // R7: now corrupt I
        drive(1'b1, 1'b1, mk(14'h0ABC, 14'(16411), 4'd0), "R7 I mismatch");
        drive(1'b1, 1'b1, mk(14'(16411), 14'(16412), 4'd0), "R8 both sticky");

        // R10 / R11: disable clears, re-enable waits for zero
        drive(1'b0, 1'b0, 32'h0, "R10 clear after errors");
        drive(1'b1, 1'b1, mk(14'd3, 14'd3, 4'd0), "R11 unlocked after restart");
        drive(1'b1, 1'b1, mk(14'd0, 14'd0, 4'd0), "R11 both relock");
        drive(1'b1, 1'b1, mk(14'd1, 14'd1, 4'd0), "R5 clean after relock");

        repeat (4) @(posedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule